// File: doc/BRIEF.md
# Next-PC and Link Select Unit

This unit holds the program counter of a single-cycle 32-bit processor and decides, every clock, which address the counter loads next. The candidates are the sequential address (PC+4), a PC-relative conditional branch, a direct jump that keeps the top PC bits, a jump through a register value, and three fixed vectors for reset, interrupt and illegal opcode. A small priority stage places reset first, then the interrupt request, then the illegal-opcode flag, and only then the target picked by the control decoder.

The unit also names the register-file write destination. The decoder can pick the `rd` field, the `rt` field, the fixed link register 31 or the exception register 27. An interrupt or an illegal opcode forces register 27 so that the return address (PC+4) can be saved there. The PC register, PC+4 and the destination index are all outputs. Instruction memory, the register file and the ALU sit outside the unit.

Top module: `pc_steer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pcOut` loads 0x80000000 after that edge; reset overrides every other input.
- R2: With no reset, interrupt or illegal opcode, `pcSel` code 0 (and the unused code 7) loads `pcOut`+4.
- R3: `pcSel` code 1 is a conditional branch. With `branchNe`=0 it is taken when `aluZero`=1, and with `branchNe`=1 it is taken when `aluZero`=0. A taken branch loads `pcOut`+4 + (sign-extended `immField` shifted left by 2). A branch that is not taken loads `pcOut`+4.
- R4: `pcSel` code 2 loads {`pcOut`[31:28], `jumpField`, 2'b00}.
- R5: `pcSel` code 3 loads `regTarget` with its bits [1:0] cleared.
- R6: `pcSel` codes 4, 5 and 6 load 0x80000000, 0x80000040 and 0x80000080.
- R7: `irq` high without reset loads 0x80000080, whatever the values of `badOp` and `pcSel`.
- R8: `badOp` high without reset or `irq` loads 0x80000040, whatever the value of `pcSel`.
- R9: When neither `irq` nor `badOp` is high, `destReg` is `rdIdx` for `waSel`=0, `rtIdx` for 1, 31 for 2 and 27 for 3, in the same cycle.
- R10: When `irq` or `badOp` is high, `destReg` is 27 for any `waSel`, in the same cycle.
- R11: `pcOut`[1:0] is always 0 after reset.
- R12: `pcPlus4` always equals `pcOut`+4 (modulo 2^32), combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Interrupt request |
| badOp | input | 1 | Illegal opcode in the current instruction |
| pcSel | input | 3 | Next-PC select code from control |
| waSel | input | 2 | Write-address select code from control |
| jumpField | input | 26 | Jump target field of the instruction |
| immField | input | 16 | Immediate field of the instruction |
| regTarget | input | 32 | Register value for indirect jumps |
| aluZero | input | 1 | ALU zero flag from the compare subtraction |
| branchNe | input | 1 | Branch type: 0 = branch if equal, 1 = branch if not equal |
| rdIdx | input | 5 | rd register number |
| rtIdx | input | 5 | rt register number |
| pcOut | output | 32 | Registered program counter |
| pcPlus4 | output | 32 | pcOut + 4 |
| destReg | output | 5 | Register-file write destination |

## Verification
`destReg` and `pcPlus4` are combinational, so they are due in the same cycle as the inputs that set them. The bench samples them 1 time unit after it drives new values at the falling edge. `pcOut` passes through one register, so the next address set by a cycle's inputs is due one rising edge later. The bench keeps its predicted value until the following falling edge and compares it there, before it drives new stimulus. Directed vectors cover each select code, both branch senses in both directions, and every pairing of the priority inputs. Random cycles then cover the rest.

// File: rtl/pc_steer_pkg.sv
package pc_steer_pkg;

  // pcSel encodings driven by the decoder
  localparam logic [2:0] PCS_SEQ    = 3'd0;
  localparam logic [2:0] PCS_BRANCH = 3'd1;
  localparam logic [2:0] PCS_JUMP   = 3'd2;
  localparam logic [2:0] PCS_REG    = 3'd3;
  localparam logic [2:0] PCS_VRST   = 3'd4;
  localparam logic [2:0] PCS_VBAD   = 3'd5;
  localparam logic [2:0] PCS_VIRQ   = 3'd6;

  typedef enum logic [2:0] {
    TGT_SEQ, TGT_BRANCH, TGT_JUMP, TGT_REG, TGT_RESET, TGT_BADOP, TGT_IRQ
  } tgt_e;

  typedef enum logic [1:0] {
    DST_RD, DST_RT, DST_LINK, DST_EXC
  } dst_e;

  typedef struct packed {
    tgt_e target;
    dst_e dest;
  } steer_t;

endpackage

// File: rtl/pc_steer_ctrl.sv
module pc_steer_ctrl
  import pc_steer_pkg::*;
(
  input  logic       rst,
  input  logic       irq,
  input  logic       badOp,
  input  logic [2:0] pcSel,
  input  logic [1:0] waSel,
  input  logic       aluZero,
  input  logic       branchNe,
  output steer_t     steer
);

  logic branchTaken;
  logic excActive;

  // beq: taken on zero; bne: taken on non-zero
  assign branchTaken = aluZero ^ branchNe;
  assign excActive   = irq | badOp;

  always_comb begin
    steer.target = TGT_SEQ;
    if (rst) begin
      steer.target = TGT_RESET;
    end else if (irq) begin
      steer.target = TGT_IRQ;
    end else if (badOp) begin
      steer.target = TGT_BADOP;
    end else begin
      unique case (pcSel)
        PCS_SEQ:    steer.target = TGT_SEQ;
        PCS_BRANCH: steer.target = branchTaken ? TGT_BRANCH : TGT_SEQ;
        PCS_JUMP:   steer.target = TGT_JUMP;
        PCS_REG:    steer.target = TGT_REG;
        PCS_VRST:   steer.target = TGT_RESET;
        PCS_VBAD:   steer.target = TGT_BADOP;
        PCS_VIRQ:   steer.target = TGT_IRQ;
        default:    steer.target = TGT_SEQ;
      endcase
    end
  end

  always_comb begin
    if (excActive) begin
      steer.dest = DST_EXC;
    end else begin
      unique case (waSel)
        2'd0:    steer.dest = DST_RD;
        2'd1:    steer.dest = DST_RT;
        2'd2:    steer.dest = DST_LINK;
        default: steer.dest = DST_EXC;
      endcase
    end
  end

endmodule

// File: rtl/pc_steer_dp.sv
module pc_steer_dp
  import pc_steer_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          JW       = 26,
  parameter int          IMMW     = 16,
  parameter int          RW       = 5,
  parameter logic [31:0] RST_VEC  = 32'h8000_0000,
  parameter logic [31:0] BAD_VEC  = 32'h8000_0040,
  parameter logic [31:0] IRQ_VEC  = 32'h8000_0080,
  parameter int          LINK_REG = 31,
  parameter int          EXC_REG  = 27
) (
  input  logic            clk,
  input  steer_t          steer,
  input  logic [JW-1:0]   jumpField,
  input  logic [IMMW-1:0] immField,
  input  logic [XLEN-1:0] regTarget,
  input  logic [RW-1:0]   rdIdx,
  input  logic [RW-1:0]   rtIdx,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] pcPlus4,
  output logic [RW-1:0]   destReg
);

  localparam int SEXW  = XLEN - IMMW - 2;
  localparam int KEEPW = XLEN - JW - 2;

  logic [XLEN-1:0] pcReg;
  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] branchOff;
  logic [XLEN-1:0] branchPc;
  logic [XLEN-1:0] jumpPc;
  logic [XLEN-1:0] regPc;
  logic [XLEN-1:0] nextPc;

  // Dedicated adders: ALU is busy with the compare subtraction
  assign seqPc     = pcReg + XLEN'(4);
  assign branchOff = {{SEXW{immField[IMMW-1]}}, immField, 2'b00};
  assign branchPc  = seqPc + branchOff;
  assign jumpPc    = {pcReg[XLEN-1 -: KEEPW], jumpField, 2'b00};
  assign regPc     = regTarget & ~XLEN'(3);

  always_comb begin
    unique case (steer.target)
      TGT_SEQ:    nextPc = seqPc;
      TGT_BRANCH: nextPc = branchPc;
      TGT_JUMP:   nextPc = jumpPc;
      TGT_REG:    nextPc = regPc;
      TGT_RESET:  nextPc = XLEN'(RST_VEC);
      TGT_BADOP:  nextPc = XLEN'(BAD_VEC);
      TGT_IRQ:    nextPc = XLEN'(IRQ_VEC);
      default:    nextPc = seqPc;
    endcase
  end

  // Reset arrives as TGT_RESET from control, so the load is synchronous
  always_ff @(posedge clk) begin
    pcReg <= nextPc;
  end

  always_comb begin
    unique case (steer.dest)
      DST_RD:   destReg = rdIdx;
      DST_RT:   destReg = rtIdx;
      DST_LINK: destReg = RW'(LINK_REG);
      default:  destReg = RW'(EXC_REG);
    endcase
  end

  assign pcOut   = pcReg;
  assign pcPlus4 = seqPc;

endmodule

// File: rtl/pc_steer.sv
module pc_steer
  import pc_steer_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          JW       = 26,
  parameter int          IMMW     = 16,
  parameter int          RW       = 5,
  parameter logic [31:0] RST_VEC  = 32'h8000_0000,
  parameter logic [31:0] BAD_VEC  = 32'h8000_0040,
  parameter logic [31:0] IRQ_VEC  = 32'h8000_0080,
  parameter int          LINK_REG = 31,
  parameter int          EXC_REG  = 27
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            irq,
  input  logic            badOp,
  input  logic [2:0]      pcSel,
  input  logic [1:0]      waSel,
  input  logic [JW-1:0]   jumpField,
  input  logic [IMMW-1:0] immField,
  input  logic [XLEN-1:0] regTarget,
  input  logic            aluZero,
  input  logic            branchNe,
  input  logic [RW-1:0]   rdIdx,
  input  logic [RW-1:0]   rtIdx,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] pcPlus4,
  output logic [RW-1:0]   destReg
);

  steer_t steer;

  pc_steer_ctrl u_ctrl (
    .rst      (rst),
    .irq      (irq),
    .badOp    (badOp),
    .pcSel    (pcSel),
    .waSel    (waSel),
    .aluZero  (aluZero),
    .branchNe (branchNe),
    .steer    (steer)
  );

  pc_steer_dp #(
    .XLEN     (XLEN),
    .JW       (JW),
    .IMMW     (IMMW),
    .RW       (RW),
    .RST_VEC  (RST_VEC),
    .BAD_VEC  (BAD_VEC),
    .IRQ_VEC  (IRQ_VEC),
    .LINK_REG (LINK_REG),
    .EXC_REG  (EXC_REG)
  ) u_dp (
    .clk       (clk),
    .steer     (steer),
    .jumpField (jumpField),
    .immField  (immField),
    .regTarget (regTarget),
    .rdIdx     (rdIdx),
    .rtIdx     (rtIdx),
    .pcOut     (pcOut),
    .pcPlus4   (pcPlus4),
    .destReg   (destReg)
  );

endmodule

// File: rtl/pc_steer_chk.sv
module pc_steer_chk #(
  parameter int          XLEN    = 32,
  parameter int          RW      = 5,
  parameter logic [31:0] RST_VEC = 32'h8000_0000,
  parameter logic [31:0] BAD_VEC = 32'h8000_0040,
  parameter logic [31:0] IRQ_VEC = 32'h8000_0080
) (
  input logic            clk,
  input logic            rst,
  input logic            irq,
  input logic            badOp,
  input logic [2:0]      pcSel,
  input logic [1:0]      waSel,
  input logic            aluZero,
  input logic            branchNe,
  input logic [XLEN-1:0] pcOut,
  input logic [XLEN-1:0] pcPlus4,
  input logic [RW-1:0]   destReg
);

  logic seenReset = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) seenReset <= 1'b1;
  end

  assert_reset_vec_R1: assert property (@(posedge clk)
    rst |=> pcOut == XLEN'(RST_VEC));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst || !seenReset)
    (!irq && !badOp && pcSel == 3'd0) |=> pcOut == $past(pcPlus4));

  assert_branch_skip_R3: assert property (@(posedge clk) disable iff (rst || !seenReset)
    (!irq && !badOp && pcSel == 3'd1 && (aluZero == branchNe)) |=> pcOut == $past(pcPlus4));

  assert_irq_vec_R7: assert property (@(posedge clk) disable iff (rst || !seenReset)
    irq |=> pcOut == XLEN'(IRQ_VEC));

  assert_badop_vec_R8: assert property (@(posedge clk) disable iff (rst || !seenReset)
    (!irq && badOp) |=> pcOut == XLEN'(BAD_VEC));

  assert_link_reg_R9: assert property (@(posedge clk) disable iff (rst || !seenReset)
    (!irq && !badOp && waSel == 2'd2) |-> destReg == RW'(31));

  assert_exc_reg_R10: assert property (@(posedge clk) disable iff (rst || !seenReset)
    (irq || badOp) |-> destReg == RW'(27));

  assert_aligned_R11: assert property (@(posedge clk) disable iff (rst || !seenReset)
    pcOut[1:0] == 2'b00);

endmodule

bind pc_steer pc_steer_chk #(
  .XLEN    (XLEN),
  .RW      (RW),
  .RST_VEC (RST_VEC),
  .BAD_VEC (BAD_VEC),
  .IRQ_VEC (IRQ_VEC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .badOp    (badOp),
  .pcSel    (pcSel),
  .waSel    (waSel),
  .aluZero  (aluZero),
  .branchNe (branchNe),
  .pcOut    (pcOut),
  .pcPlus4  (pcPlus4),
  .destReg  (destReg)
);

// File: tb/sim_pc_steer.sv
module sim_pc_steer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, irq, badOp, aluZero, branchNe;
  logic [2:0]  pcSel;
  logic [1:0]  waSel;
  logic [25:0] jumpField;
  logic [15:0] immField;
  logic [31:0] regTarget;
  logic [4:0]  rdIdx, rtIdx;
  logic [31:0] pcOut, pcPlus4;
  logic [4:0]  destReg;

  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 0;
  logic [31:0] refPc;
  string refTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_steer u0 (
    .clk(clk), .rst(rst), .irq(irq), .badOp(badOp), .pcSel(pcSel), .waSel(waSel),
    .jumpField(jumpField), .immField(immField), .regTarget(regTarget),
    .aluZero(aluZero), .branchNe(branchNe), .rdIdx(rdIdx), .rtIdx(rtIdx),
    .pcOut(pcOut), .pcPlus4(pcPlus4), .destReg(destReg)
  );

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference for the next address
  function automatic logic [31:0] refNext(output string tag);
    logic [31:0] seq;
    logic signed [31:0] off;
    seq = refPc + 32'd4;
    if (rst)        begin tag = "R1"; return 32'h8000_0000; end
    if (irq)        begin tag = "R7"; return 32'h8000_0080; end
    if (badOp)      begin tag = "R8"; return 32'h8000_0040; end
    case (pcSel)
      3'd1: begin
        tag = "R3";
        off = 32'(signed'(immField)) * 4;
        if ((branchNe == 1'b0 && aluZero) || (branchNe == 1'b1 && !aluZero))
          return seq + off;
        return seq;
      end
      3'd2: begin tag = "R4"; return {refPc[31:28], jumpField, 2'b00}; end
      3'd3: begin tag = "R5"; return {regTarget[31:2], 2'b00}; end
      3'd4: begin tag = "R6"; return 32'h8000_0000; end
      3'd5: begin tag = "R6"; return 32'h8000_0040; end
      3'd6: begin tag = "R6"; return 32'h8000_0080; end
      default: begin tag = "R2"; return seq; end
    endcase
  endfunction

  task automatic apply(bit r, bit i, bit b, logic [2:0] ps, logic [1:0] ws,
                       logic [25:0] jf, logic [15:0] im, logic [31:0] rt,
                       bit z, bit ne);
    logic [31:0] nxt;
    logic [4:0]  expDest;
    string tag;
    rst = r; irq = i; badOp = b; pcSel = ps; waSel = ws; jumpField = jf;
    immField = im; regTarget = rt; aluZero = z; branchNe = ne;
    rdIdx = 5'($urandom); rtIdx = 5'($urandom);
    #1;
    if (i || b) expDest = 5'd27;
    else case (ws)
      2'd0: expDest = rdIdx;
      2'd1: expDest = rtIdx;
      2'd2: expDest = 5'd31;
      default: expDest = 5'd27;
    endcase
    if (!$isunknown(refPc))
      check32((i || b) ? "R10" : "R9", 32'(destReg), 32'(expDest));
    nxt = refNext(tag);
    @(posedge clk);
    @(negedge clk);
    refPc = nxt;
    check32(tag, pcOut, refPc);
    check32("R12", pcPlus4, refPc + 32'd4);
    check32("R11", {30'd0, pcOut[1:0]}, 32'd0);
  endtask

  initial begin
    refPc = 'x;
    @(negedge clk);
    apply(1, 0, 0, 3'd2, 2'd0, 26'h3ff_ffff, 16'h0, 32'h0, 0, 0);   // R1 reset state
    apply(1, 1, 1, 3'd3, 2'd1, 26'h0, 16'h0, 32'h1234, 0, 0);       // R1 beats irq
    apply(0, 0, 0, 3'd0, 2'd0, 26'h0, 16'h0, 32'h0, 0, 0);          // R2
    apply(0, 0, 0, 3'd7, 2'd1, 26'h0, 16'h0, 32'h0, 0, 0);          // R2 code 7
    apply(0, 0, 0, 3'd1, 2'd2, 26'h0, 16'h0010, 32'h0, 1, 0);       // R3 beq taken fwd
    apply(0, 0, 0, 3'd1, 2'd3, 26'h0, 16'h0010, 32'h0, 0, 0);       // R3 beq not taken
    apply(0, 0, 0, 3'd1, 2'd0, 26'h0, 16'hfff0, 32'h0, 0, 1);       // R3 bne taken back
    apply(0, 0, 0, 3'd1, 2'd1, 26'h0, 16'hfff0, 32'h0, 1, 1);       // R3 bne not taken
    apply(0, 0, 0, 3'd1, 2'd1, 26'h0, 16'h8000, 32'h0, 1, 0);       // R3 most negative
    apply(0, 0, 0, 3'd2, 2'd2, 26'h2ab_cdef, 16'h0, 32'h0, 0, 0);   // R4
    apply(0, 0, 0, 3'd3, 2'd0, 26'h0, 16'h0, 32'h1357_9bdf, 0, 0);  // R5 low bits set
    apply(0, 0, 0, 3'd2, 2'd2, 26'h3ff_ffff, 16'h0, 32'h0, 0, 0);   // R4 upper kept
    apply(0, 0, 0, 3'd4, 2'd0, 26'h0, 16'h0, 32'h0, 0, 0);          // R6
    apply(0, 0, 0, 3'd5, 2'd1, 26'h0, 16'h0, 32'h0, 0, 0);          // R6
    apply(0, 0, 0, 3'd6, 2'd2, 26'h0, 16'h0, 32'h0, 0, 0);          // R6
    apply(0, 0, 1, 3'd2, 2'd0, 26'h1, 16'h0, 32'h0, 0, 0);          // R8 over jump, R10
    apply(0, 1, 1, 3'd3, 2'd1, 26'h0, 16'h0, 32'h4444, 0, 0);       // R7 over badOp
    apply(0, 1, 0, 3'd1, 2'd2, 26'h0, 16'h0100, 32'h0, 1, 0);       // R7 over branch
    apply(0, 0, 0, 3'd0, 2'd3, 26'h0, 16'h0, 32'h0, 0, 0);          // R9 code 3
    for (int n = 0; n < 3000; n++) begin
      apply(($urandom % 97) == 0, ($urandom % 13) == 0, ($urandom % 11) == 0,
            3'($urandom), 2'($urandom), 26'($urandom), 16'($urandom),
            $urandom, 1'($urandom), 1'($urandom));
    end
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule